// File: doc/BRIEF.md
# Transmit checksum offload classifier

This block watches an outgoing Ethernet frame one byte per beat and decides, by the time the last byte has gone past, whether a downstream checksum engine may insert the IPv4 header checksum and the TCP/UDP checksum. It walks the frame in a single pass with no buffering. It skips the two address fields, follows an optional VLAN tag and an optional LLC/SNAP header to the real EtherType, and then reads the IPv4 or IPv6 header fields that matter: version, header length, total or payload length, fragmentation and the upper-layer protocol. It performs no checksum arithmetic.

The verdict is a 3-bit status code and two permission flags. They are registered in the cycle after the end-of-frame beat and hold until the next frame ends. Offload is armed per frame by the enable and no-CRC inputs, which are sampled on the start-of-frame beat. A frame that already carries its CRC is never touched.

The parser is one state machine. Its states are ST_IDLE (outside a frame), ST_MAC (address bytes), ST_ETYPE (two type/length bytes), ST_VLAN (two tag-control bytes), ST_LLC (six LLC/SNAP bytes), ST_IP4 and ST_IP6 (IP header and payload counting) and ST_DRAIN (verdict fixed, rest ignored). Its transitions are:
- any state goes to ST_MAC on a start-of-frame beat;
- ST_MAC goes to ST_ETYPE after the twelfth byte;
- ST_ETYPE goes to ST_VLAN, ST_LLC, ST_IP4, ST_IP6 or ST_DRAIN, depending on the type value;
- ST_VLAN returns to ST_ETYPE after two bytes;
- ST_LLC returns to ST_ETYPE after six good bytes, or goes to ST_DRAIN on a mismatch;
- ST_IP4 and ST_IP6 go to ST_DRAIN on a header error;
- every state goes to ST_IDLE after an end-of-frame beat.

Top module: `tx_csum_classifier`

## Requirements
- R1: After reset the status is 000 and both flags are 0. The status and flags change only in the cycle after a beat with valid and end-of-frame both high. In every other cycle they hold.
- R2: If offload enable is low or no-CRC is high on the start-of-frame beat, that frame reports status 000 with both flags 0, whatever its content.
- R3: The type field is bytes 12-13, big-endian. 0x0800 selects IPv4, 0x86DD selects IPv6, 0x8100 selects a 4-byte VLAN tag whose 2 control bytes are followed by a new type field, and a value of 1500 or less selects LLC. Any other outer value, or a frame ending before the type field is complete, reports 100.
- R4: A frame that ends inside the VLAN tag, or before the type field after it is complete, reports 001. After a tag, a type that is neither IP nor LLC (including a second 0x8100) reports 011.
- R5: The LLC header is AA AA 03 followed by three organisation bytes, then a type field. A first byte other than AA reports 100. A wrong second or third byte, or a frame ending inside the LLC header or its type field, reports 010. After SNAP, a type that is not IP reports 011.
- R6: For IPv4, the version nibble (byte 0, bits 7:4) must be 4, the header-length nibble (bits 3:0) at least 5, and the total length (bytes 2-3) at least four times that nibble. For IPv6, the version nibble must be 6. A violation, or a frame ending before the 20/40-byte header is complete, reports 011.
- R7: For IPv4, a set more-fragments bit (byte 6, bit 5) or a non-zero 13-bit offset (byte 6 bits 4:0, byte 7) reports 101 with the IPv4 flag set. For IPv6, a next-header value of 44 reports 101. The don't-fragment bit alone is not fragmentation.
- R8: A protocol byte (IPv4 byte 9, IPv6 byte 6) other than 6 (TCP) or 17 (UDP) reports 110. For IPv4 the IPv4 flag is set.
- R9: Bytes are counted from the IP header start. If the frame ends with fewer than the IPv4 total length, or fewer than 40 plus the IPv6 payload length, the frame reports 111, with the IPv4 flag set for IPv4. Trailing bytes beyond that length are allowed.
- R10: A frame passing every check reports 000 with the TCP/UDP flag set. The IPv4 flag is set only for IPv4. The TCP/UDP flag is never set with a non-zero status. When several checks fail, 101 wins over 110, and 110 wins over 111.
- R11: Beats with valid low are ignored, whatever their other inputs. Valid beats outside a frame are ignored. A start-of-frame in the middle of a frame restarts parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| offload_en | input | 1 | Checksum offload wanted for this frame |
| no_crc | input | 1 | Frame already carries its CRC; suppresses offload |
| status_code | output | 3 | Offload status of the last finished frame |
| ip_csum_ok | output | 1 | IPv4 header checksum may be inserted |
| l4_csum_ok | output | 1 | TCP/UDP checksum may be inserted |

## Verification
The bench aims at the points where one header hands over to the next. These are a frame cut off one byte into a VLAN tag, an LLC header broken at its first byte rather than its second, and an IPv4 header cut off at byte ten. A parser that mis-tracked its byte counter across a tag or SNAP header would report the wrong code there, or would report success. It also sets the don't-fragment bit alone, puts an offset bit in byte 6, and combines fragmentation with a foreign protocol, or a foreign protocol with a short payload. A wrong bit mask or a wrong priority shows up as 000 or as the lower-priority code. Trailing padding, idle beats with garbage start/end markers, a restart in the middle of a frame, and output stability during a frame catch designs that count beats that are not valid or update the status early.

// File: rtl/csum_cls_pkg.sv
package csum_cls_pkg;

    localparam int POS_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_ETYPE,
        ST_VLAN,
        ST_LLC,
        ST_IP4,
        ST_IP6,
        ST_DRAIN
    } cls_state_e;

    localparam logic [2:0] CODE_OK      = 3'b000;
    localparam logic [2:0] CODE_VLAN    = 3'b001;
    localparam logic [2:0] CODE_SNAP    = 3'b010;
    localparam logic [2:0] CODE_NOTIP   = 3'b011;
    localparam logic [2:0] CODE_UNKNOWN = 3'b100;
    localparam logic [2:0] CODE_FRAG    = 3'b101;
    localparam logic [2:0] CODE_PROTO   = 3'b110;
    localparam logic [2:0] CODE_SHORT   = 3'b111;

    typedef struct packed {
        cls_state_e       state;
        logic             en;
        logic             vlan;
        logic             snap;
        logic             err_set;
        logic [2:0]       err_code;
        logic             hdr_done;
        logic             frag;
        logic [7:0]       proto;
        logic [POS_W-1:0] cnt;
        logic [POS_W:0]   tot;
    } cls_view_t;

endpackage

// File: rtl/csum_cls_fsm.sv
module csum_cls_fsm
    import csum_cls_pkg::*;
#(
    parameter int unsigned ADDR_BYTES    = 12,
    parameter logic [15:0] TYPE_VLAN     = 16'h8100,
    parameter logic [15:0] TYPE_IP4      = 16'h0800,
    parameter logic [15:0] TYPE_IP6      = 16'h86DD,
    parameter int unsigned MAX_LEN_FIELD = 1500,
    parameter int unsigned IP6_HDR_BYTES = 40,
    parameter int unsigned IP6_FRAG_NH   = 44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       offload_en,
    input  logic       no_crc,
    output cls_view_t  view_nxt,
    output logic       frame_end
);

    localparam logic [POS_W-1:0] MAC_LAST = POS_W'(ADDR_BYTES - 1);
    localparam logic [POS_W-1:0] IP6_HDR  = POS_W'(IP6_HDR_BYTES);
    localparam logic [15:0]      LEN_MAX  = 16'(MAX_LEN_FIELD);

    cls_view_t        cur, nxt;
    logic [7:0]       ehi, nxt_ehi;
    logic [5:0]       hlen, nxt_hlen;
    logic [15:0]      etype;
    logic [15:0]      v4_tot;
    logic [POS_W-1:0] cnt_inc;

    assign frame_end = in_valid && in_eof;
    assign view_nxt  = nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= cls_view_t'('0);
            ehi  <= '0;
            hlen <= '0;
        end else begin
            cur  <= nxt;
            ehi  <= nxt_ehi;
            hlen <= nxt_hlen;
            if (frame_end) cur.state <= ST_IDLE;
        end
    end

    // next-state and field capture
    always_comb begin
        nxt      = cur;
        nxt_ehi  = ehi;
        nxt_hlen = hlen;
        etype    = {ehi, in_data};
        v4_tot   = {cur.tot[15:8], in_data};
        cnt_inc  = (&cur.cnt) ? cur.cnt : cur.cnt + 1'b1;
        if (in_valid && in_sof) begin
            nxt       = cls_view_t'('0);
            nxt.state = ST_MAC;
            nxt.cnt   = POS_W'(1);
            nxt.en    = offload_en && !no_crc;
            nxt_hlen  = '0;
        end else if (in_valid) begin
            unique case (cur.state)
                ST_IDLE, ST_DRAIN: ;
                ST_MAC: begin
                    nxt.cnt = cur.cnt + 1'b1;
                    if (cur.cnt == MAC_LAST) begin
                        nxt.state = ST_ETYPE;
                        nxt.cnt   = '0;
                    end
                end
                ST_ETYPE: begin
                    if (cur.cnt == '0) begin
                        nxt_ehi = in_data;
                        nxt.cnt = POS_W'(1);
                    end else begin
                        nxt.cnt = '0;
                        if (etype == TYPE_IP4) begin
                            nxt.state = ST_IP4;
                        end else if (etype == TYPE_IP6) begin
                            nxt.state = ST_IP6;
                        end else if (etype == TYPE_VLAN && !cur.vlan && !cur.snap) begin
                            nxt.state = ST_VLAN;
                            nxt.vlan  = 1'b1;
                        end else if (etype <= LEN_MAX && !cur.snap) begin
                            nxt.state = ST_LLC;
                        end else begin
                            nxt.state    = ST_DRAIN;
                            nxt.err_set  = 1'b1;
                            nxt.err_code = (cur.vlan || cur.snap) ? CODE_NOTIP : CODE_UNKNOWN;
                        end
                    end
                end
                ST_VLAN: begin
                    nxt.cnt = cur.cnt + 1'b1;
                    if (cur.cnt == POS_W'(1)) begin
                        nxt.state = ST_ETYPE;
                        nxt.cnt   = '0;
                    end
                end
                ST_LLC: begin
                    nxt.cnt = cur.cnt + 1'b1;
                    if ((cur.cnt == POS_W'(0) && in_data != 8'hAA) ||
                        (cur.cnt == POS_W'(1) && in_data != 8'hAA) ||
                        (cur.cnt == POS_W'(2) && in_data != 8'h03)) begin
                        nxt.state    = ST_DRAIN;
                        nxt.err_set  = 1'b1;
                        nxt.err_code = (cur.cnt == '0) ? CODE_UNKNOWN : CODE_SNAP;
                    end else if (cur.cnt == POS_W'(5)) begin
                        nxt.state = ST_ETYPE;
                        nxt.snap  = 1'b1;
                        nxt.cnt   = '0;
                    end
                end
                ST_IP4: begin
                    nxt.cnt = cnt_inc;
                    if (cnt_inc == {{(POS_W-6){1'b0}}, hlen}) nxt.hdr_done = 1'b1;
                    case (cur.cnt)
                        POS_W'(0): begin
                            if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) begin
                                nxt.state    = ST_DRAIN;
                                nxt.err_set  = 1'b1;
                                nxt.err_code = CODE_NOTIP;
                            end else begin
                                nxt_hlen = {in_data[3:0], 2'b00};
                            end
                        end
                        POS_W'(2): nxt.tot = {1'b0, in_data, 8'h00};
                        POS_W'(3): begin
                            nxt.tot = {1'b0, v4_tot};
                            if (v4_tot < {{(POS_W-6){1'b0}}, hlen}) begin
                                nxt.state    = ST_DRAIN;
                                nxt.err_set  = 1'b1;
                                nxt.err_code = CODE_NOTIP;
                            end
                        end
                        POS_W'(6): nxt.frag  = in_data[5] || (|in_data[4:0]);
                        POS_W'(7): nxt.frag  = cur.frag || (|in_data);
                        POS_W'(9): nxt.proto = in_data;
                        default: ;
                    endcase
                end
                ST_IP6: begin
                    nxt.cnt = cnt_inc;
                    if (cnt_inc == IP6_HDR) nxt.hdr_done = 1'b1;
                    case (cur.cnt)
                        POS_W'(0): begin
                            if (in_data[7:4] != 4'd6) begin
                                nxt.state    = ST_DRAIN;
                                nxt.err_set  = 1'b1;
                                nxt.err_code = CODE_NOTIP;
                            end
                        end
                        POS_W'(4): nxt.tot = {1'b0, in_data, 8'h00};
                        POS_W'(5): nxt.tot = {1'b0, v4_tot} + (POS_W+1)'(IP6_HDR_BYTES);
                        POS_W'(6): begin
                            nxt.proto = in_data;
                            nxt.frag  = (in_data == 8'(IP6_FRAG_NH));
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/csum_cls_verdict.sv
module csum_cls_verdict
    import csum_cls_pkg::*;
#(
    parameter logic [7:0] PROTO_TCP = 8'd6,
    parameter logic [7:0] PROTO_UDP = 8'd17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cls_view_t  view_nxt,
    input  logic       frame_end,
    output logic [2:0] status_code,
    output logic       ip_csum_ok,
    output logic       l4_csum_ok
);

    logic [2:0] code_c;
    logic       ip_c;
    logic       l4_c;

    always_comb begin
        code_c = CODE_UNKNOWN;
        ip_c   = 1'b0;
        if (!view_nxt.en) begin
            code_c = CODE_OK;
        end else if (view_nxt.err_set) begin
            code_c = view_nxt.err_code;
        end else begin
            unique case (view_nxt.state)
                ST_IDLE, ST_MAC: code_c = CODE_UNKNOWN;
                ST_ETYPE: code_c = view_nxt.snap ? CODE_SNAP :
                                   view_nxt.vlan ? CODE_VLAN : CODE_UNKNOWN;
                ST_VLAN:  code_c = CODE_VLAN;
                ST_LLC:   code_c = CODE_SNAP;
                ST_DRAIN: code_c = CODE_NOTIP;
                ST_IP4, ST_IP6: begin
                    if (!view_nxt.hdr_done) begin
                        code_c = CODE_NOTIP;
                    end else begin
                        ip_c = (view_nxt.state == ST_IP4);
                        if (view_nxt.frag)
                            code_c = CODE_FRAG;
                        else if (view_nxt.proto != PROTO_TCP && view_nxt.proto != PROTO_UDP)
                            code_c = CODE_PROTO;
                        else if ({1'b0, view_nxt.cnt} < view_nxt.tot)
                            code_c = CODE_SHORT;
                        else
                            code_c = CODE_OK;
                    end
                end
            endcase
        end
        l4_c = view_nxt.en && (code_c == CODE_OK);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_code <= CODE_OK;
            ip_csum_ok  <= 1'b0;
            l4_csum_ok  <= 1'b0;
        end else if (frame_end) begin
            status_code <= code_c;
            ip_csum_ok  <= ip_c;
            l4_csum_ok  <= l4_c;
        end
    end

endmodule

// File: rtl/tx_csum_classifier.sv
module tx_csum_classifier
    import csum_cls_pkg::*;
#(
    parameter int unsigned ADDR_BYTES    = 12,
    parameter logic [15:0] TYPE_VLAN     = 16'h8100,
    parameter logic [15:0] TYPE_IP4      = 16'h0800,
    parameter logic [15:0] TYPE_IP6      = 16'h86DD,
    parameter int unsigned MAX_LEN_FIELD = 1500,
    parameter int unsigned IP6_HDR_BYTES = 40,
    parameter int unsigned IP6_FRAG_NH   = 44,
    parameter logic [7:0]  PROTO_TCP     = 8'd6,
    parameter logic [7:0]  PROTO_UDP     = 8'd17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       offload_en,
    input  logic       no_crc,
    output logic [2:0] status_code,
    output logic       ip_csum_ok,
    output logic       l4_csum_ok
);

    cls_view_t view_nxt;
    logic      frame_end;

    csum_cls_fsm #(
        .ADDR_BYTES   (ADDR_BYTES),
        .TYPE_VLAN    (TYPE_VLAN),
        .TYPE_IP4     (TYPE_IP4),
        .TYPE_IP6     (TYPE_IP6),
        .MAX_LEN_FIELD(MAX_LEN_FIELD),
        .IP6_HDR_BYTES(IP6_HDR_BYTES),
        .IP6_FRAG_NH  (IP6_FRAG_NH)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .offload_en(offload_en),
        .no_crc    (no_crc),
        .view_nxt  (view_nxt),
        .frame_end (frame_end)
    );

    csum_cls_verdict #(
        .PROTO_TCP(PROTO_TCP),
        .PROTO_UDP(PROTO_UDP)
    ) verdict_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .view_nxt   (view_nxt),
        .frame_end  (frame_end),
        .status_code(status_code),
        .ip_csum_ok (ip_csum_ok),
        .l4_csum_ok (l4_csum_ok)
    );

endmodule

// File: rtl/tx_csum_classifier_chk.sv
module tx_csum_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic       in_eof,
    input logic       offload_en,
    input logic       no_crc,
    input logic [2:0] status_code,
    input logic       ip_csum_ok,
    input logic       l4_csum_ok
);

    logic armed_q;
    logic armed_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (in_valid && in_sof) armed_q <= offload_en && !no_crc;
    end

    assign armed_now = (in_valid && in_sof) ? (offload_en && !no_crc) : armed_q;

    AST_HOLD_BETWEEN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eof) |=> ($stable(status_code) && $stable(ip_csum_ok) && $stable(l4_csum_ok))); // R1

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && !armed_now) |=> (status_code == 3'b000 && !ip_csum_ok && !l4_csum_ok)); // R2

    AST_L4_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        l4_csum_ok |-> (status_code == 3'b000)); // R10

    AST_IPFLAG_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        ip_csum_ok |-> (status_code == 3'b000 || status_code == 3'b101 ||
                        status_code == 3'b110 || status_code == 3'b111)); // R7

endmodule

bind tx_csum_classifier tx_csum_classifier_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .offload_en (offload_en),
    .no_crc     (no_crc),
    .status_code(status_code),
    .ip_csum_ok (ip_csum_ok),
    .l4_csum_ok (l4_csum_ok)
);

// File: tb/tx_csum_classifier_tb_top.sv
module tx_csum_classifier_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       offload_en = 1'b1;
    logic       no_crc = 1'b0;
    logic [2:0] status_code;
    logic       ip_csum_ok;
    logic       l4_csum_ok;

    int n_checks = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] fb [0:255];
    int flen = 0;

    always #4 clk = ~clk;

    tx_csum_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .offload_en(offload_en), .no_crc(no_crc),
        .status_code(status_code), .ip_csum_ok(ip_csum_ok), .l4_csum_ok(l4_csum_ok)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        fb[flen] = b;
        flen++;
    endtask

    task automatic pad(input int n);
        for (int i = 0; i < n; i++) put(8'(i + 3));
    endtask

    task automatic eth(input logic [15:0] t);
        flen = 0;
        for (int i = 0; i < 12; i++) put(8'h10 + 8'(i));
        put(t[15:8]);
        put(t[7:0]);
    endtask

    task automatic ip4(input logic [7:0] vihl, input logic [15:0] tot,
                       input logic [7:0] b6, input logic [7:0] b7, input logic [7:0] proto);
        put(vihl); put(8'h00); put(tot[15:8]); put(tot[7:0]);
        put(8'h12); put(8'h34); put(b6); put(b7);
        put(8'd64); put(proto); put(8'h00); put(8'h00);
        for (int i = 0; i < 8; i++) put(8'hC0 + 8'(i));
    endtask

    task automatic ip6(input logic [7:0] nh, input logic [15:0] pl);
        put(8'h60); put(8'h00); put(8'h00); put(8'h00);
        put(pl[15:8]); put(pl[7:0]); put(nh); put(8'd64);
        for (int i = 0; i < 32; i++) put(8'h20 + 8'(i));
    endtask

    task automatic send_rng(input int lo, input int hi, input bit sof, input bit eof,
                            input bit en, input bit ncrc, input bit gaps);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[i];
            in_sof = sof && (i == lo); in_eof = eof && (i == hi);
            offload_en = en; no_crc = ncrc;
            if (gaps && i != hi) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hAA; in_sof = 1'b1; in_eof = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send(input bit en, input bit ncrc, input bit gaps);
        send_rng(0, flen - 1, 1'b1, 1'b1, en, ncrc, gaps);
    endtask

    task automatic check(input logic [2:0] c, input logic ip, input logic l4, input string tag);
        n_checks++;
        if (status_code !== c || ip_csum_ok !== ip || l4_csum_ok !== l4) begin
            n_bad++;
            $display("FAIL %s: got code=%b ip=%b l4=%b expected code=%b ip=%b l4=%b",
                     tag, status_code, ip_csum_ok, l4_csum_ok, c, ip, l4);
        end
    endtask

    task automatic t_reset();
        check(3'b000, 1'b0, 1'b0, "R1 reset values");
    endtask

    task automatic t_clean();
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b000, 1'b1, 1'b1, "R10 ipv4 tcp complete");
        eth(16'h0800); ip4(8'h45, 16'd28, 8'h40, 8'h00, 8'd17); pad(20);
        send(1, 0, 1); check(3'b000, 1'b1, 1'b1, "R11 ipv4 udp gaps, DF only, padding (R7 R9)");
        eth(16'h86DD); ip6(8'd17, 16'd8); pad(8);
        send(1, 0, 0); check(3'b000, 1'b0, 1'b1, "R10 ipv6 udp complete");
    endtask

    task automatic t_disarm();
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 1, 0); check(3'b000, 1'b0, 1'b0, "R2 no-crc set");
        eth(16'h88B5); pad(30);
        send(1, 0, 0); check(3'b100, 1'b0, 1'b0, "R3 unknown type");
        send(0, 0, 0); check(3'b000, 1'b0, 1'b0, "R2 offload disabled");
        flen = 0; pad(10);
        send(1, 0, 0); check(3'b100, 1'b0, 1'b0, "R3 ends before type");
    endtask

    task automatic t_vlan();
        eth(16'h8100); put(8'h00); put(8'h05); put(8'h08); put(8'h00);
        ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b000, 1'b1, 1'b1, "R3 vlan ipv4 tcp");
        eth(16'h8100); put(8'h00);
        send(1, 0, 0); check(3'b001, 1'b0, 1'b0, "R4 vlan truncated");
        eth(16'h8100); put(8'h00); put(8'h05); put(8'h88); put(8'hB5); pad(20);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R4 vlan inner not ip");
        eth(16'h8100); put(8'h00); put(8'h05); put(8'h81); put(8'h00); pad(20);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R4 double tag");
    endtask

    task automatic t_snap();
        eth(16'h0030); put(8'hAA); put(8'hAA); put(8'h03); put(8'h00); put(8'h00); put(8'h00);
        put(8'h08); put(8'h00); ip4(8'h45, 16'd28, 8'h00, 8'h00, 8'd17); pad(8);
        send(1, 0, 0); check(3'b000, 1'b1, 1'b1, "R5 snap ipv4 udp");
        eth(16'h0030); put(8'hAA); put(8'hAA); put(8'h07); pad(10);
        send(1, 0, 0); check(3'b010, 1'b0, 1'b0, "R5 bad control byte");
        eth(16'h0030); put(8'hF0); put(8'hF0); put(8'h03); pad(10);
        send(1, 0, 0); check(3'b100, 1'b0, 1'b0, "R5 not snap first byte");
        eth(16'h0030); put(8'hAA); put(8'hAA);
        send(1, 0, 0); check(3'b010, 1'b0, 1'b0, "R5 snap truncated");
        eth(16'h0030); put(8'hAA); put(8'hAA); put(8'h03); put(8'h00); put(8'h00); put(8'h00);
        put(8'h88); put(8'hB5); pad(10);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R5 snap inner not ip");
    endtask

    task automatic t_iphdr();
        eth(16'h0800); ip4(8'h65, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 ipv4 bad version");
        eth(16'h0800); ip4(8'h44, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 ipv4 ihl 4");
        eth(16'h0800); ip4(8'h45, 16'd16, 8'h00, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 total below header");
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd6); flen = 24;
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 ipv4 header cut");
        eth(16'h86DD); ip6(8'd6, 16'd8); fb[14] = 8'h40; pad(8);
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 ipv6 bad version");
        eth(16'h86DD); ip6(8'd6, 16'd0); flen = 44;
        send(1, 0, 0); check(3'b011, 1'b0, 1'b0, "R6 ipv6 header cut");
    endtask

    task automatic t_frag();
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h20, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b101, 1'b1, 1'b0, "R7 ipv4 MF");
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h01, 8'd6); pad(20);
        send(1, 0, 0); check(3'b101, 1'b1, 1'b0, "R7 ipv4 offset low");
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h01, 8'h00, 8'd6); pad(20);
        send(1, 0, 0); check(3'b101, 1'b1, 1'b0, "R7 ipv4 offset high");
        eth(16'h86DD); ip6(8'd44, 16'd8); pad(8);
        send(1, 0, 0); check(3'b101, 1'b0, 1'b0, "R7 ipv6 fragment header");
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h20, 8'h00, 8'd1); pad(20);
        send(1, 0, 0); check(3'b101, 1'b1, 1'b0, "R10 frag beats proto");
    endtask

    task automatic t_proto_short();
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd1); pad(20);
        send(1, 0, 0); check(3'b110, 1'b1, 1'b0, "R8 ipv4 icmp");
        eth(16'h86DD); ip6(8'd58, 16'd8); pad(8);
        send(1, 0, 0); check(3'b110, 1'b0, 1'b0, "R8 ipv6 icmp");
        eth(16'h0800); ip4(8'h45, 16'd60, 8'h00, 8'h00, 8'd1); pad(5);
        send(1, 0, 0); check(3'b110, 1'b1, 1'b0, "R10 proto beats short");
        eth(16'h0800); ip4(8'h45, 16'd60, 8'h00, 8'h00, 8'd6); pad(39);
        send(1, 0, 0); check(3'b111, 1'b1, 1'b0, "R9 ipv4 one byte short");
        eth(16'h86DD); ip6(8'd6, 16'd20); pad(10);
        send(1, 0, 0); check(3'b111, 1'b0, 1'b0, "R9 ipv6 short");
    endtask

    task automatic t_hold_restart();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 8'h08; in_sof = 1'b0; in_eof = 1'b0;
        end
        @(negedge clk); in_valid = 1'b0;
        check(3'b111, 1'b0, 1'b0, "R11 beats outside frame ignored");
        eth(16'h0800); ip4(8'h45, 16'd40, 8'h00, 8'h00, 8'd6); pad(20);
        send_rng(0, 19, 1'b1, 1'b0, 1, 0, 0);
        check(3'b111, 1'b0, 1'b0, "R1 hold during frame");
        send_rng(20, flen - 1, 1'b0, 1'b1, 1, 0, 0);
        check(3'b000, 1'b1, 1'b1, "R1 update at end");
        eth(16'h8100); put(8'h00); put(8'h05);
        send_rng(0, flen - 1, 1'b1, 1'b0, 1, 0, 0);
        eth(16'h86DD); ip6(8'd6, 16'd4); pad(4);
        send(1, 0, 0); check(3'b000, 1'b0, 1'b1, "R11 restart mid frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_disarm();
        t_vlan();
        t_snap();
        t_iphdr();
        t_frag();
        t_proto_short();
        t_hold_restart();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule